// File: doc/BRIEF.md
# One-Bit Controller Program Sequencer

This block supplies instructions to a one-bit controller. An 8-bit program counter addresses a 256-byte program store. Each fetched byte is split into a 4-bit opcode (upper nybble) and a 4-bit operand address (lower nybble), which go to the execution logic. Every instruction takes two clock cycles. The byte is read in a fetch cycle and presented in the following execute cycle. The counter advances when the execute cycle ends.

The store is filled before a run through a plain byte write port. While that port is enabled, the counter stays parked at zero. Opcode 0x0 and opcode 0xF are both no-ops, so an erased store of all zeros or all ones does nothing harmful. Each of these two opcodes raises its own one-cycle flag. The 0xF flag also acts as a restart: it joins the external reset on the counter's clear path, so the next fetch comes from address zero and the program cycle can be shorter than the full store. Jump, return and skip opcodes (0xC, 0xD, 0xE) pass through the sequence like any other instruction. The counter value is brought out so that an address display can follow it.

Top module: `prog_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter to 0 and drives `exec_o`, both flags, `opcode_o` and `operand_o` to 0 after the next rising edge. `rst` overrides loading and execution.
- R2: Outside reset and loading, cycles alternate between fetch (`exec_o`=0) and execute (`exec_o`=1). The first cycle after reset or loading is a fetch.
- R3: During an execute cycle, `opcode_o` equals bits [7:4] and `operand_o` equals bits [3:0] of the stored byte at address `pc_o`. During any other cycle both read 0.
- R4: `pc_o` keeps the same value across an instruction's fetch and execute cycles. After an execute cycle whose opcode is not 0xF, it increases by one.
- R5: After the instruction at address 255 executes, the next fetch is from address 0.
- R6: Executing opcode 0x0 raises `nop_lo_o` for exactly the execute cycle. The counter advances as usual.
- R7: Executing opcode 0xF raises `nop_hi_o` for exactly the execute cycle. The following fetch is from address 0.
- R8: Opcodes 0xC, 0xD and 0xE advance the counter by one, exactly like an ordinary instruction.
- R9: While `load_en` is 1, each cycle writes `load_data` at `load_addr`, `pc_o` reads 0 and `exec_o` reads 0. After `load_en` falls, execution begins with a fetch from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Program store write enable; holds the counter at 0 |
| load_addr | input | 8 | Store address for the byte being written |
| load_data | input | 8 | Byte to write into the store |
| pc_o | output | 8 | Current program counter |
| exec_o | output | 1 | High during the execute cycle of an instruction |
| opcode_o | output | 4 | Opcode of the executing instruction |
| operand_o | output | 4 | Port or scratchpad address of the executing instruction |
| nop_lo_o | output | 1 | One-cycle flag when opcode 0x0 executes |
| nop_hi_o | output | 1 | One-cycle flag when opcode 0xF executes (restart) |

## Verification
The assertions assume that `rst` and `load_en` change only between clock edges. They also assume that every store address fetched during a run was written first, so that opcode decoding never sees an unknown value. The bench changes all inputs on the falling clock edge. It loads each program image completely before releasing `load_en`, and fetches only from addresses that image has written. Reset and reloading are applied mid-run, in the middle of an instruction, so that the checked properties have to recover from an interrupted fetch/execute pair.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_t;
endpackage

// File: rtl/seq_store.sv
// Program store: one write port, one registered read port (block RAM shape).
module seq_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/seq_counter.sv
// Program counter plus fetch/execute phase register.
module seq_counter
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              restart,
  output logic [ADDR_W-1:0] pc,
  output logic              exec
);
  phase_t phase_q;
  logic [ADDR_W-1:0] pc_q;
  logic clear;

  // external reset and restart opcode share one clear path
  assign clear = rst || hold || (phase_q == PH_EXEC && restart);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      pc_q <= '0;
    end else if (phase_q == PH_EXEC) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign pc   = pc_q;
  assign exec = (phase_q == PH_EXEC);
endmodule

// File: rtl/seq_decode.sv
// Splits the fetched byte and decodes the two no-op flags.
module seq_decode #(
  parameter int OPC_W = 4,
  parameter int OPD_W = 4
) (
  input  logic                   exec,
  input  logic [OPC_W+OPD_W-1:0] instr,
  output logic [OPC_W-1:0]       opcode,
  output logic [OPD_W-1:0]       operand,
  output logic                   nop_lo,
  output logic                   nop_hi
);
  localparam logic [OPC_W-1:0] OPC_IDLE    = '0;
  localparam logic [OPC_W-1:0] OPC_RESTART = '1;

  logic [OPC_W-1:0] opc_raw;
  assign opc_raw = instr[OPC_W+OPD_W-1 -: OPC_W];

  always_comb begin
    opcode  = '0;
    operand = '0;
    nop_lo  = 1'b0;
    nop_hi  = 1'b0;
    if (exec) begin
      opcode  = opc_raw;
      operand = instr[OPD_W-1:0];
      nop_lo  = (opc_raw == OPC_IDLE);
      nop_hi  = (opc_raw == OPC_RESTART);
    end
  end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4,
  parameter int OPD_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_en,
  input  logic [ADDR_W-1:0]      load_addr,
  input  logic [OPC_W+OPD_W-1:0] load_data,
  output logic [ADDR_W-1:0]      pc_o,
  output logic                   exec_o,
  output logic [OPC_W-1:0]       opcode_o,
  output logic [OPD_W-1:0]       operand_o,
  output logic                   nop_lo_o,
  output logic                   nop_hi_o
);
  localparam int DATA_W = OPC_W + OPD_W;

  logic [DATA_W-1:0] instr_q;
  logic              exec_w;
  logic              fetch_en;
  logic              restart_w;

  assign fetch_en = !exec_w && !load_en && !rst;

  seq_counter #(.ADDR_W(ADDR_W)) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (load_en),
    .restart (restart_w),
    .pc      (pc_o),
    .exec    (exec_w)
  );

  seq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .wr_en   (load_en && !rst),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_en   (fetch_en),
    .rd_addr (pc_o),
    .rd_data (instr_q)
  );

  seq_decode #(.OPC_W(OPC_W), .OPD_W(OPD_W)) dec_i (
    .exec    (exec_w),
    .instr   (instr_q),
    .opcode  (opcode_o),
    .operand (operand_o),
    .nop_lo  (nop_lo_o),
    .nop_hi  (restart_w)
  );

  assign exec_o   = exec_w;
  assign nop_hi_o = restart_w;
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [ADDR_W-1:0] pc_o,
  input logic              exec_o,
  input logic              nop_lo_o,
  input logic              nop_hi_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !exec_o && !nop_lo_o && !nop_hi_o));

  // R2
  exec_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_o && !load_en) |=> exec_o);

  // R2
  fetch_follows_exec_chk: assert property (@(posedge clk) disable iff (rst)
    exec_o |=> !exec_o);

  // R4
  pc_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec_o && !load_en) |=> $stable(pc_o));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_o && !nop_hi_o && !load_en) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_o && nop_hi_o && !load_en) |=> (pc_o == '0));

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nop_lo_o, nop_hi_o}) && ((nop_lo_o || nop_hi_o) -> exec_o));

  // R9
  load_parks_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (pc_o == '0 && !exec_o));
endmodule

bind prog_sequencer prog_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .load_en  (load_en),
  .pc_o     (pc_o),
  .exec_o   (exec_o),
  .nop_lo_o (nop_lo_o),
  .nop_hi_o (nop_hi_o)
);

// File: tb/prog_sequencer_tb_top.sv
module prog_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [7:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] pc_o;
  logic       exec_o;
  logic [3:0] opcode_o;
  logic [3:0] operand_o;
  logic       nop_lo_o;
  logic       nop_hi_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] img [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_sequencer dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .pc_o(pc_o), .exec_o(exec_o), .opcode_o(opcode_o),
    .operand_o(operand_o), .nop_lo_o(nop_lo_o), .nop_hi_o(nop_hi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Write img[0..n-1]; counter must stay parked while loading.
  task automatic load_image(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_addr = i[7:0];
      load_data = img[i];
    end
    @(negedge clk);
    chk("R9 pc held", {24'd0, pc_o}, 32'd0);
    chk("R9 exec low", {31'd0, exec_o}, 32'd0);
    load_en = 1'b0;
  endtask

  // One fetch/execute pair of the instruction at exp_pc.
  task automatic expect_exec(input logic [7:0] exp_pc);
    logic [3:0] op;
    logic [7:0] nxt;
    op  = img[exp_pc][7:4];
    nxt = (op == 4'hF) ? 8'd0 : exp_pc + 8'd1;
    @(negedge clk);
    chk("R2 exec phase", {31'd0, exec_o}, 32'd1);
    chk("R4 pc in exec", {24'd0, pc_o}, {24'd0, exp_pc});
    chk("R3 opcode", {28'd0, opcode_o}, {28'd0, op});
    chk("R3 operand", {28'd0, operand_o}, {28'd0, img[exp_pc][3:0]});
    chk("R6 nop_lo", {31'd0, nop_lo_o}, {31'd0, op == 4'h0});
    chk("R7 nop_hi", {31'd0, nop_hi_o}, {31'd0, op == 4'hF});
    @(negedge clk);
    chk("R2 fetch phase", {31'd0, exec_o}, 32'd0);
    chk("R3 fields idle", {24'd0, opcode_o, operand_o}, 32'd0);
    chk("R6 flags idle", {30'd0, nop_lo_o, nop_hi_o}, 32'd0);
    if (op == 4'hF)
      chk("R7 restart pc", {24'd0, pc_o}, {24'd0, nxt});
    else if (op >= 4'hC)
      chk("R8 ctl advance", {24'd0, pc_o}, {24'd0, nxt});
    else
      chk("R4 pc advance", {24'd0, pc_o}, {24'd0, nxt});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pc", {24'd0, pc_o}, 32'd0);
    chk("R1 exec", {31'd0, exec_o}, 32'd0);
    chk("R1 flags", {30'd0, nop_lo_o, nop_hi_o}, 32'd0);
    chk("R1 fields", {24'd0, opcode_o, operand_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_demo();
    img[0] = 8'h11; img[1] = 8'h32; img[2] = 8'h83; img[3] = 8'h97; img[4] = 8'hF0;
    load_image(5);
    for (int lap = 0; lap < 2; lap++)
      for (int a = 0; a < 5; a++) expect_exec(a[7:0]);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 256; i++) begin
      logic [3:0] op;
      op = (i[3:0] == 4'hF) ? 4'hC : i[3:0];
      img[i] = {op, i[7:4]};
    end
    load_image(256);
    for (int a = 0; a < 256; a++) expect_exec(a[7:0]);
    chk("R5 wrap to 0", {24'd0, pc_o}, 32'd0);
    expect_exec(8'd0);
  endtask

  task automatic t_self_restart();
    img[0] = 8'hF3;
    load_image(1);
    expect_exec(8'd0);
    expect_exec(8'd0);
    chk("R7 stays at 0", {24'd0, pc_o}, 32'd0);
  endtask

  task automatic t_reset_midrun();
    img[0] = 8'h15; img[1] = 8'hD2; img[2] = 8'hE1; img[3] = 8'h07; img[4] = 8'hFF;
    load_image(5);
    expect_exec(8'd0);
    expect_exec(8'd1);
    @(negedge clk);            // execute cycle of address 2
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run pc", {24'd0, pc_o}, 32'd0);
    chk("R1 mid-run exec", {31'd0, exec_o}, 32'd0);
    rst = 1'b0;
    for (int a = 0; a < 5; a++) expect_exec(a[7:0]);
    expect_exec(8'd0);
  endtask

  task automatic t_reload_midrun();
    expect_exec(8'd1);
    @(negedge clk);            // execute cycle of address 2
    img[0] = 8'h00; img[1] = 8'hF4;
    load_en = 1'b1; load_addr = 8'd0; load_data = img[0];
    @(negedge clk);
    chk("R9 park mid-run", {24'd0, pc_o}, 32'd0);
    load_addr = 8'd1; load_data = img[1];
    @(negedge clk);
    chk("R9 exec held", {31'd0, exec_o}, 32'd0);
    load_en = 1'b0;
    expect_exec(8'd0);
    expect_exec(8'd1);
    expect_exec(8'd0);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset();
    t_demo();
    t_wrap();
    t_self_restart();
    t_reset_midrun();
    t_reload_midrun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule